// File: doc/BRIEF.md
# Sprite Attribute Store with Page-Copy Engine

This block keeps the per-object attribute table a video controller scans each frame. The table is a private 256-byte store made of 64 four-byte entries. Within an entry, byte 0 holds the vertical position less one, byte 1 the tile index, byte 2 the attribute flags and byte 3 the horizontal position. In the attribute byte, bits 1:0 are the upper palette bits, bit 5 places the object behind the background, bit 6 mirrors it left to right and bit 7 mirrors it top to bottom. The block stores these bytes and does not interpret them.

Software can reach the store one byte at a time. It loads a pointer through one register select. It then reads or writes through a data select, and every data access steps the pointer by one. A single write to a third select starts a bulk load. That write names a 256-byte-aligned page of processor memory. The engine requests the processor bus, waits for the grant, and copies the whole page into the store. The copy starts at the current pointer and wraps at the end of the store. Each byte takes one read cycle on the bus followed by one internal write cycle. After the last byte the engine releases the bus and pulses a completion flag.

Top module: `spr_attr_dma`

## Requirements
- R1: After reset the pointer is 0, and `bus_req`, `mem_rd`, `dma_busy`, `dma_done` and `reg_rdata` are all 0.
- R2: Register select 0 loads the pointer from `reg_wdata`. A write with select 1 stores `reg_wdata` at the pointer. A read with select 1 returns the byte at the pointer on `reg_rdata` in the cycle after the read strobe. Each select-1 access, read or write, advances the pointer by 1.
- R3: The pointer wraps from 255 to 0, so consecutive data accesses continue at address 0.
- R4: A write of N with register select 2 copies processor addresses N*256 through N*256+255 in ascending order. `mem_addr` is formed as {N, byte index}.
- R5: `bus_req` rises in the cycle after the trigger write. No `mem_rd` is issued while `bus_gnt` is low.
- R6: Copied bytes land starting at the pointer value held when the copy was triggered, wrapping modulo 256. After the copy the pointer is back at that start value.
- R7: From the trigger write until `dma_busy` falls, every register access is ignored. This covers pointer loads, data reads and writes, and further triggers.
- R8: Each byte uses one cycle with `mem_rd` high, then one cycle in which `mem_rdata` (returned one cycle after the read) is written into the store. A low `bus_gnt` holds off the next read.
- R9: After the 256th store write, `bus_req` is low and `dma_done` is high for exactly one cycle. In the following cycle `dma_busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 pointer, 1 data, 2 copy trigger |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Data-port read result, valid the cycle after `reg_rd` |
| bus_req | output | 1 | Processor bus request, high for the whole copy |
| bus_gnt | input | 1 | Processor bus grant |
| mem_addr | output | 16 | Processor memory read address |
| mem_rd | output | 1 | Processor memory read strobe |
| mem_rdata | input | 8 | Processor memory data, one cycle after `mem_rd` |
| dma_busy | output | 1 | Copy in progress, including the completion cycle |
| dma_done | output | 1 | One-cycle copy completion pulse |

## Verification
The embedded properties check these rules on every cycle:
- Reads happen only under both request and grant.
- Every store write from the engine follows a read.
- The source page holds steady while the bus is held.
- The completion pulse is single and drops the request.
- Every data access advances the pointer.

Only the bench's scenarios can show that the right bytes land at the right places. The reference model and full read-backs cover the wrapped destination, the lockout of register traffic mid-copy, and the final pointer value.

// File: rtl/spr_dma_pkg.sv
package spr_dma_pkg;

   // register selects seen on reg_sel
   localparam logic [1:0] SEL_PTR  = 2'd0;
   localparam logic [1:0] SEL_DATA = 2'd1;
   localparam logic [1:0] SEL_COPY = 2'd2;

   // byte roles inside one 4-byte object entry
   localparam int ENT_BYTES   = 4;
   localparam int ENT_YPOS    = 0;
   localparam int ENT_TILE    = 1;
   localparam int ENT_ATTR    = 2;
   localparam int ENT_XPOS    = 3;

   // attribute byte fields
   localparam int ATTR_PAL_LO = 0;
   localparam int ATTR_PAL_HI = 1;
   localparam int ATTR_BEHIND = 5;
   localparam int ATTR_HMIR   = 6;
   localparam int ATTR_VMIR   = 7;

   typedef enum logic [2:0] {
      CP_IDLE,
      CP_REQ,
      CP_RD,
      CP_WR,
      CP_DONE
   } copy_state_e;

endpackage

// File: rtl/spr_ptr.sv
module spr_ptr #(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          step,
   output logic [AW-1:0] ptr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr <= '0;
      else if (load)
         ptr <= load_val;
      else if (step)
         ptr <= ptr + 1'b1;   // natural wrap at 2**AW
   end

endmodule

// File: rtl/spr_ram.sv
module spr_ram #(
   parameter int AW     = 8,
   parameter int DW     = 8,
   parameter bit RD_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   input  logic          we,
   input  logic [DW-1:0] wdata,
   input  logic          re,
   output logic [DW-1:0] rdata
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         cells[addr] <= wdata;
   end

   generate
      if (RD_REG) begin : g_rd_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               rdata <= '0;
            else if (re)
               rdata <= cells[addr];
         end
      end else begin : g_rd_comb
         logic unused_re;
         assign unused_re = re;
         assign rdata     = cells[addr];
      end
   endgenerate

endmodule

// File: rtl/spr_copy_fsm.sv
module spr_copy_fsm
   import spr_dma_pkg::*;
#(
   parameter int SPR_AW = 8,
   parameter int BUS_AW = 16,
   parameter int DW     = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     trig,
   input  logic [BUS_AW-SPR_AW-1:0] trig_page,
   input  logic                     bus_gnt,
   input  logic [DW-1:0]            mem_rdata,
   output logic                     bus_req,
   output logic                     mem_rd,
   output logic [BUS_AW-1:0]        mem_addr,
   output logic                     wr_en,
   output logic [DW-1:0]            wr_data,
   output logic                     busy,
   output logic                     done
);

   localparam int PAGE_W = BUS_AW - SPR_AW;

   copy_state_e           st_q;
   logic [PAGE_W-1:0]     page_q;
   logic [SPR_AW-1:0]     idx_q;
   logic                  last_idx;

   assign last_idx = (idx_q == {SPR_AW{1'b1}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= CP_IDLE;
         page_q <= '0;
         idx_q  <= '0;
      end else begin
         unique case (st_q)
            CP_IDLE: if (trig) begin
               st_q   <= CP_REQ;
               page_q <= trig_page;
               idx_q  <= '0;
            end
            CP_REQ:  if (bus_gnt) st_q <= CP_RD;
            CP_RD:   if (bus_gnt) st_q <= CP_WR;
            CP_WR: begin
               if (last_idx) begin
                  st_q <= CP_DONE;
               end else begin
                  st_q  <= CP_RD;
                  idx_q <= idx_q + 1'b1;
               end
            end
            CP_DONE: st_q <= CP_IDLE;
            default: st_q <= CP_IDLE;
         endcase
      end
   end

   assign bus_req  = (st_q == CP_REQ) || (st_q == CP_RD) || (st_q == CP_WR);
   assign mem_rd   = (st_q == CP_RD) && bus_gnt;
   assign mem_addr = {page_q, idx_q};
   assign wr_en    = (st_q == CP_WR);
   assign wr_data  = mem_rdata;
   assign busy     = (st_q != CP_IDLE);
   assign done     = (st_q == CP_DONE);

   // R5: a read is only issued while the bus is requested and granted
   p_rd_granted_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> (bus_req && bus_gnt));

   // R8: every store write from the engine follows a bus read
   p_wr_after_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(mem_rd));

   // R7: the source page cannot change while the bus is held
   p_page_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && $past(bus_req)) |->
         mem_addr[BUS_AW-1:SPR_AW] == $past(mem_addr[BUS_AW-1:SPR_AW]));

   // R9: completion drops the request and lasts one cycle
   p_done_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !bus_req);

   p_done_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

endmodule

// File: rtl/spr_attr_dma.sv
module spr_attr_dma
   import spr_dma_pkg::*;
#(
   parameter int SPR_AW = 8,
   parameter int BUS_AW = 16,
   parameter int DW     = 8,
   parameter bit RD_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        reg_sel,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [DW-1:0]     reg_wdata,
   output logic [DW-1:0]     reg_rdata,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic [BUS_AW-1:0] mem_addr,
   output logic              mem_rd,
   input  logic [DW-1:0]     mem_rdata,
   output logic              dma_busy,
   output logic              dma_done
);

   localparam int PAGE_W = BUS_AW - SPR_AW;

   generate
      if (PAGE_W < 1 || PAGE_W > DW) begin : g_bad_page
         $error("spr_attr_dma: page number must fit the register data width");
      end
      if (SPR_AW > DW) begin : g_bad_ptr
         $error("spr_attr_dma: pointer must load from one register write");
      end
      if (SPR_AW < 2) begin : g_bad_depth
         $error("spr_attr_dma: store must hold at least one 4-byte entry");
      end
   endgenerate

   logic              cpu_open;
   logic              ptr_load, cpu_wr, cpu_rd, trig;
   logic              dma_wr;
   logic [DW-1:0]     dma_wdata;
   logic              ram_we;
   logic [DW-1:0]     ram_wdata;
   logic [SPR_AW-1:0] ptr;

   // register traffic is locked out while the engine owns the store
   assign cpu_open = !dma_busy;
   assign ptr_load = cpu_open && reg_wr && (reg_sel == SEL_PTR);
   assign cpu_wr   = cpu_open && reg_wr && (reg_sel == SEL_DATA);
   assign cpu_rd   = cpu_open && reg_rd && (reg_sel == SEL_DATA);
   assign trig     = cpu_open && reg_wr && (reg_sel == SEL_COPY);

   assign ram_we    = cpu_wr || dma_wr;
   assign ram_wdata = dma_wr ? dma_wdata : reg_wdata;

   spr_ptr #(.AW(SPR_AW)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ptr_load),
      .load_val (reg_wdata[SPR_AW-1:0]),
      .step     (ram_we || cpu_rd),
      .ptr      (ptr)
   );

   spr_ram #(.AW(SPR_AW), .DW(DW), .RD_REG(RD_REG)) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (ptr),
      .we    (ram_we),
      .wdata (ram_wdata),
      .re    (cpu_rd),
      .rdata (reg_rdata)
   );

   spr_copy_fsm #(.SPR_AW(SPR_AW), .BUS_AW(BUS_AW), .DW(DW)) u_copy (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig      (trig),
      .trig_page (reg_wdata[PAGE_W-1:0]),
      .bus_gnt   (bus_gnt),
      .mem_rdata (mem_rdata),
      .bus_req   (bus_req),
      .mem_rd    (mem_rd),
      .mem_addr  (mem_addr),
      .wr_en     (dma_wr),
      .wr_data   (dma_wdata),
      .busy      (dma_busy),
      .done      (dma_done)
   );

   // R2: every store access advances the pointer by one
   p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we || cpu_rd) |=> ptr == SPR_AW'($past(ptr) + 1'b1));

   // R7: a pointer load attempted during a copy leaves the pointer alone
   p_busy_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_busy && !dma_wr) |=> $stable(ptr));

endmodule

// File: tb/spr_attr_dma_tb.sv
module spr_attr_dma_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [1:0]  reg_sel;
   logic        reg_wr, reg_rd;
   logic [7:0]  reg_wdata, reg_rdata;
   logic        bus_req, bus_gnt, mem_rd, dma_busy, dma_done;
   logic [15:0] mem_addr;
   logic [7:0]  mem_rdata;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spr_attr_dma u_dut (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_addr(mem_addr),
      .mem_rd(mem_rd), .mem_rdata(mem_rdata), .dma_busy(dma_busy),
      .dma_done(dma_done)
   );

   function automatic logic [7:0] patt(input logic [15:0] a);
      return a[7:0] * 8'd5 + a[15:8] * 8'd11 + 8'h3C;
   endfunction

   // processor memory: data one cycle after the read strobe
   always @(posedge clk) begin
      if (mem_rd) mem_rdata <= patt(mem_addr);
   end

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int         m_st;      // 0 idle, 1 request, 2 read, 3 write, 4 done
   int         m_ptr, m_cnt, m_page;
   logic [7:0] m_mem [256];
   logic [7:0] m_rdata;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_ptr = 0; m_cnt = 0; m_page = 0; m_rdata = 8'h00;
      end else begin
         case (m_st)
            0: begin
               if (reg_wr && reg_sel == 2'd0) m_ptr = reg_wdata;
               else if (reg_wr && reg_sel == 2'd1) begin
                  m_mem[m_ptr] = reg_wdata; m_ptr = (m_ptr + 1) % 256;
               end else if (reg_wr && reg_sel == 2'd2) begin
                  m_page = reg_wdata; m_cnt = 0; m_st = 1;
               end
               if (reg_rd && reg_sel == 2'd1) begin
                  m_rdata = m_mem[m_ptr]; m_ptr = (m_ptr + 1) % 256;
               end
            end
            1: if (bus_gnt) m_st = 2;
            2: if (bus_gnt) m_st = 3;
            3: begin
               m_mem[m_ptr] = patt(16'(m_page * 256 + m_cnt));
               m_ptr = (m_ptr + 1) % 256;
               if (m_cnt == 255) m_st = 4;
               else begin m_cnt++; m_st = 2; end
            end
            default: m_st = 0;
         endcase
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         check("R5", "bus_req",  32'(bus_req),  32'(m_st >= 1 && m_st <= 3));
         check("R8", "mem_rd",   32'(mem_rd),   32'(m_st == 2 && bus_gnt));
         if (mem_rd)
            check("R4", "mem_addr", 32'(mem_addr), 32'(m_page * 256 + m_cnt));
         check("R9", "dma_done", 32'(dma_done), 32'(m_st == 4));
         check("R7", "dma_busy", 32'(dma_busy), 32'(m_st != 0));
         check("R2", "reg_rdata", 32'(reg_rdata), 32'(m_rdata));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input logic [1:0] sel, input logic [7:0] d);
      reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [7:0] exp, input string req);
      reg_sel = 2'd1; reg_rd = 1'b1;
      @(posedge clk); #1;
      reg_rd = 1'b0;
      check(req, "data read", 32'(reg_rdata), 32'(exp));
   endtask

   task automatic wait_done();
      for (int i = 0; i < 2000 && dma_done !== 1'b1; i++) begin
         @(posedge clk); #1;
      end
      check("R9", "done seen", 32'(dma_done), 32'd1);
      check("R9", "req low at done", 32'(bus_req), 32'd0);
      @(posedge clk); #1;
      check("R9", "done single cycle", 32'(dma_done), 32'd0);
      check("R9", "busy low after done", 32'(dma_busy), 32'd0);
   endtask

   task automatic run();
      rst_n = 1'b0; reg_sel = 2'd0; reg_wr = 1'b0; reg_rd = 1'b0;
      reg_wdata = 8'h00; bus_gnt = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #2;
      // R1 reset state
      check("R1", "bus_req",   32'(bus_req),   32'd0);
      check("R1", "mem_rd",    32'(mem_rd),    32'd0);
      check("R1", "dma_busy",  32'(dma_busy),  32'd0);
      check("R1", "dma_done",  32'(dma_done),  32'd0);
      check("R1", "reg_rdata", 32'(reg_rdata), 32'd0);
      @(posedge clk); #1;
      // R1: pointer starts at 0
      wr(2'd1, 8'hC7);
      wr(2'd0, 8'h00);
      rd_chk(8'hC7, "R1");

      // R2 byte access with auto-increment
      wr(2'd0, 8'h10);
      wr(2'd1, 8'hA1); wr(2'd1, 8'hB2); wr(2'd1, 8'hC3); wr(2'd1, 8'hD4);
      wr(2'd0, 8'h10);
      rd_chk(8'hA1, "R2"); rd_chk(8'hB2, "R2");
      rd_chk(8'hC3, "R2"); rd_chk(8'hD4, "R2");

      // R3 pointer wrap
      wr(2'd0, 8'hFE);
      wr(2'd1, 8'h11); wr(2'd1, 8'h22); wr(2'd1, 8'h33);
      wr(2'd0, 8'hFE);
      rd_chk(8'h11, "R3"); rd_chk(8'h22, "R3"); rd_chk(8'h33, "R3");
      wr(2'd0, 8'h00);
      rd_chk(8'h33, "R3");

      // R4/R5: copy page 0x12 into pointer 0 with a late grant
      wr(2'd0, 8'h00);
      wr(2'd2, 8'h12);
      for (int i = 0; i < 4; i++) begin
         check("R5", "request waits", 32'(bus_req), 32'd1);
         check("R5", "no read before grant", 32'(mem_rd), 32'd0);
         @(posedge clk); #1;
      end
      bus_gnt = 1'b1;
      wait_done();
      wr(2'd0, 8'h00);
      for (int i = 0; i < 256; i++) rd_chk(patt(16'h1200 + 16'(i)), "R4");

      // R6/R7/R8: copy page 0x80 starting at pointer 5, with traffic and a stall
      wr(2'd0, 8'h05);
      wr(2'd2, 8'h80);
      repeat (30) @(posedge clk);
      #1;
      wr(2'd2, 8'h33);      // R7 ignored trigger
      wr(2'd0, 8'h77);      // R7 ignored pointer load
      wr(2'd1, 8'hEE);      // R7 ignored data write
      reg_sel = 2'd1; reg_rd = 1'b1; @(posedge clk); #1; reg_rd = 1'b0;
      bus_gnt = 1'b0;
      @(posedge clk); #1;
      for (int i = 0; i < 3; i++) begin
         check("R8", "no read while grant low", 32'(mem_rd), 32'd0);
         @(posedge clk); #1;
      end
      bus_gnt = 1'b1;
      wait_done();
      // R6: pointer is back at the start value
      rd_chk(patt(16'h8000), "R6");
      wr(2'd0, 8'h05);
      for (int i = 0; i < 256; i++) rd_chk(patt(16'h8000 + 16'(i)), "R6");
      repeat (4) @(posedge clk);
   endtask

   initial begin
      fork
         run();
         begin
            repeat (20000) @(posedge clk);
            checks++; fails++;
            $display("FAIL watchdog run did not finish");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule